// File: doc/BRIEF.md
# Streaming Defective Pixel Corrector

This block sits in a camera's pixel pipeline and repairs known sensor defects as the raster streams through. It takes one pixel per clock, marked with a valid flag and flags for the first pixel of a frame and the first pixel of a line. It tracks the row and column of each pixel and looks the position up in an on-chip defect table. A host fills the table through a one-cycle write port. Pixels marked good leave unchanged. Pixels marked dark, bright or hot are replaced with a value built from their neighbours on the same line.

Two replacement policies are available. The copy policy repeats the previous output pixel. The average policy takes the rounded mean of the left and right neighbours, and it drops any neighbour that is itself marked defective. The policy input is captured only on the first pixel of a frame, so a whole frame is always repaired with one policy. Output order and timing match the input exactly, two clocks later. Pixels of one line must arrive on consecutive cycles. Idle cycles are allowed between lines and between frames.

Top module: `dpc_pixel_fix`

## Requirements
- R1: Every input beat appears at the output exactly 2 clocks later. pix_valid_o, pix_sof_o and pix_sol_o carry the input valid, start-of-frame and start-of-line flags of that beat.
- R2: A pixel whose table entry is 00 (good) leaves with its data unchanged.
- R3: Each table entry is 2 bits: 00 good, 01 dark, 10 bright, 11 hot. A write with map_we_i high stores map_cls_i at linear address row*LINE_PIX+col. All three nonzero codes cause replacement.
- R4: The column counter restarts at 0 on every start-of-line pixel. The row counter restarts at 0 on every start-of-frame pixel and advances by one on each other start-of-line pixel. Table lookups therefore follow the same positions in every frame.
- R5: In copy mode (mode_i=0), a defective pixel in any column except 0 is output as the previous output pixel.
- R6: In copy mode, a defective pixel in column 0 takes the value of its right neighbour if that neighbour is good. Otherwise it takes the previous output pixel.
- R7: In average mode (mode_i=1), a defective pixel whose two neighbours are good is output as (left+right+1)>>1. The sum is computed one bit wider, so 255 and 254 give 255 at 8 bits.
- R8: In average mode, column 0 uses the right neighbour in place of the missing left one. The last column (LINE_PIX-1) uses the left neighbour in place of the missing right one.
- R9: In average mode, if exactly one neighbour is defective, the other neighbour's raw value is output. If both are defective, the previous output pixel is output.
- R10: mode_i is sampled on the valid start-of-frame pixel and applies to that whole frame. Changes of mode_i during the frame have no effect until the next start-of-frame.
- R11: After reset the output flags are 0 and every table entry is 00 (good).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | Replacement policy: 0 copy, 1 average |
| map_we_i | input | 1 | Defect table write strobe |
| map_waddr_i | input | $clog2(LINE_PIX*FRAME_LINES) | Linear table address, row*LINE_PIX+col |
| map_cls_i | input | 2 | Defect code to store |
| pix_valid_i | input | 1 | Input pixel valid |
| pix_sof_i | input | 1 | Input pixel is the first of a frame |
| pix_sol_i | input | 1 | Input pixel is the first of a line |
| pix_data_i | input | PIX_W | Input pixel value |
| pix_valid_o | output | 1 | Output pixel valid |
| pix_sof_o | output | 1 | Output pixel is the first of a frame |
| pix_sol_o | output | 1 | Output pixel is the first of a line |
| pix_data_o | output | PIX_W | Output pixel value |

## Verification
The bench builds the block with PIX_W=8, LINE_PIX=6 and FRAME_LINES=3. With only 18 positions, a single frame can hold defects in the first column, in the last column, in adjacent pairs and with both neighbours bad. The 8-bit width lets the bench test full-scale neighbours for rounding overflow. Running several frames in a row checks that the counters restart on each start-of-frame and that the policy is latched per frame.

// File: rtl/dpc_pkg.sv
package dpc_pkg;
  typedef enum logic [1:0] {
    CLS_GOOD   = 2'b00,
    CLS_DARK   = 2'b01,
    CLS_BRIGHT = 2'b10,
    CLS_HOT    = 2'b11
  } defect_cls_e;

  typedef enum logic {
    FIX_COPY = 1'b0,
    FIX_AVG  = 1'b1
  } fix_mode_e;
endpackage

// File: rtl/dpc_raster_pos.sv
module dpc_raster_pos #(
  parameter int LINE_PIX    = 32,
  parameter int FRAME_LINES = 16,
  localparam int COL_W = $clog2(LINE_PIX),
  localparam int ROW_W = $clog2(FRAME_LINES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             sof_i,
  input  logic             sol_i,
  output logic [COL_W-1:0] col_o,
  output logic [ROW_W-1:0] row_o,
  output logic             first_o,
  output logic             last_o
);
  logic [COL_W-1:0] col_q;
  logic [ROW_W-1:0] row_q;

  // position of the pixel currently on the input
  always_comb begin
    if (sof_i) begin
      col_o = '0;
      row_o = '0;
    end else if (sol_i) begin
      col_o = '0;
      row_o = row_q + ROW_W'(1);
    end else begin
      col_o = col_q + COL_W'(1);
      row_o = row_q;
    end
  end

  assign first_o = (col_o == '0);
  assign last_o  = (col_o == COL_W'(LINE_PIX - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      col_q <= '0;
      row_q <= '0;
    end else if (valid_i) begin
      col_q <= col_o;
      row_q <= row_o;
    end
  end
endmodule

// File: rtl/dpc_defect_map.sv
module dpc_defect_map #(
  parameter int LINE_PIX    = 32,
  parameter int FRAME_LINES = 16,
  localparam int DEPTH  = LINE_PIX * FRAME_LINES,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int COL_W  = $clog2(LINE_PIX),
  localparam int ROW_W  = $clog2(FRAME_LINES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [1:0]        wcls_i,
  input  logic [ROW_W-1:0]  row_i,
  input  logic [COL_W-1:0]  col_i,
  output logic [1:0]        cls_o
);
  localparam logic [ADDR_W:0] DEPTH_X = (ADDR_W+1)'(DEPTH);

  logic [1:0]        cell_q [DEPTH];
  logic [ADDR_W-1:0] raddr;

  assign raddr = ADDR_W'(row_i) * ADDR_W'(LINE_PIX) + ADDR_W'(col_i);
  // positions outside the table read as good
  assign cls_o = ({1'b0, raddr} < DEPTH_X) ? cell_q[raddr] : dpc_pkg::CLS_GOOD;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) cell_q[i] <= dpc_pkg::CLS_GOOD;
    end else if (we_i && ({1'b0, waddr_i} < DEPTH_X)) begin
      cell_q[waddr_i] <= wcls_i;
    end
  end
endmodule

// File: rtl/dpc_repair.sv
module dpc_repair #(
  parameter int PIX_W = 8
) (
  input  logic             mode_i,
  input  logic             ctr_bad_i,
  input  logic [PIX_W-1:0] ctr_data_i,
  input  logic             first_i,
  input  logic             last_i,
  input  logic [PIX_W-1:0] lft_data_i,
  input  logic             lft_bad_i,
  input  logic [PIX_W-1:0] rgt_data_i,
  input  logic             rgt_bad_i,
  input  logic [PIX_W-1:0] prev_data_i,
  output logic [PIX_W-1:0] fix_data_o
);
  import dpc_pkg::*;

  logic [PIX_W-1:0] l_val, r_val, avg_val, sub_val;
  logic             l_bad, r_bad;
  logic [PIX_W:0]   sum;

  // mirror the missing neighbour at the line edges
  assign l_val = first_i ? rgt_data_i : lft_data_i;
  assign l_bad = first_i ? rgt_bad_i  : lft_bad_i;
  assign r_val = last_i  ? lft_data_i : rgt_data_i;
  assign r_bad = last_i  ? lft_bad_i  : rgt_bad_i;

  assign sum     = {1'b0, l_val} + {1'b0, r_val} + (PIX_W+1)'(1);
  assign avg_val = sum[PIX_W:1];

  always_comb begin
    if (mode_i == FIX_AVG) begin
      unique case ({l_bad, r_bad})
        2'b00:   sub_val = avg_val;
        2'b01:   sub_val = l_val;
        2'b10:   sub_val = r_val;
        default: sub_val = prev_data_i;
      endcase
    end else begin
      sub_val = (first_i && !rgt_bad_i) ? rgt_data_i : prev_data_i;
    end
  end

  assign fix_data_o = ctr_bad_i ? sub_val : ctr_data_i;
endmodule

// File: rtl/dpc_pixel_fix.sv
module dpc_pixel_fix #(
  parameter int PIX_W       = 8,
  parameter int LINE_PIX    = 32,
  parameter int FRAME_LINES = 16
) (
  input  logic                                     clk_i,
  input  logic                                     rst_ni,
  input  logic                                     mode_i,
  input  logic                                     map_we_i,
  input  logic [$clog2(LINE_PIX*FRAME_LINES)-1:0]  map_waddr_i,
  input  logic [1:0]                               map_cls_i,
  input  logic                                     pix_valid_i,
  input  logic                                     pix_sof_i,
  input  logic                                     pix_sol_i,
  input  logic [PIX_W-1:0]                         pix_data_i,
  output logic                                     pix_valid_o,
  output logic                                     pix_sof_o,
  output logic                                     pix_sol_o,
  output logic [PIX_W-1:0]                         pix_data_o
);
  import dpc_pkg::*;

  localparam int COL_W = $clog2(LINE_PIX);
  localparam int ROW_W = $clog2(FRAME_LINES);

  logic [COL_W-1:0] in_col;
  logic [ROW_W-1:0] in_row;
  logic             in_first, in_last, in_mode, in_bad;
  logic [1:0]       in_cls;

  logic             mode_q;
  logic             s1_vld, s1_sof, s1_sol, s1_bad, s1_first, s1_last, s1_mode;
  logic [PIX_W-1:0] s1_data;
  logic [PIX_W-1:0] lft_data;
  logic             lft_bad;
  logic [PIX_W-1:0] fix_data;

  dpc_raster_pos #(
    .LINE_PIX   (LINE_PIX),
    .FRAME_LINES(FRAME_LINES)
  ) i_pos (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(pix_valid_i),
    .sof_i  (pix_sof_i),
    .sol_i  (pix_sol_i),
    .col_o  (in_col),
    .row_o  (in_row),
    .first_o(in_first),
    .last_o (in_last)
  );

  dpc_defect_map #(
    .LINE_PIX   (LINE_PIX),
    .FRAME_LINES(FRAME_LINES)
  ) i_map (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (map_we_i),
    .waddr_i(map_waddr_i),
    .wcls_i (map_cls_i),
    .row_i  (in_row),
    .col_i  (in_col),
    .cls_o  (in_cls)
  );

  assign in_bad  = (in_cls != CLS_GOOD);
  // the start-of-frame pixel already uses the new policy
  assign in_mode = (pix_valid_i && pix_sof_i) ? mode_i : mode_q;

  // stage 1 holds the centre pixel; the live input is its right neighbour
  dpc_repair #(
    .PIX_W(PIX_W)
  ) i_repair (
    .mode_i     (s1_mode),
    .ctr_bad_i  (s1_bad),
    .ctr_data_i (s1_data),
    .first_i    (s1_first),
    .last_i     (s1_last),
    .lft_data_i (lft_data),
    .lft_bad_i  (lft_bad),
    .rgt_data_i (pix_data_i),
    .rgt_bad_i  (in_bad || !pix_valid_i),
    .prev_data_i(pix_data_o),
    .fix_data_o (fix_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q      <= FIX_COPY;
      s1_vld      <= 1'b0;
      s1_sof      <= 1'b0;
      s1_sol      <= 1'b0;
      s1_bad      <= 1'b0;
      s1_first    <= 1'b0;
      s1_last     <= 1'b0;
      s1_mode     <= FIX_COPY;
      s1_data     <= '0;
      lft_data    <= '0;
      lft_bad     <= 1'b0;
      pix_valid_o <= 1'b0;
      pix_sof_o   <= 1'b0;
      pix_sol_o   <= 1'b0;
      pix_data_o  <= '0;
    end else begin
      if (pix_valid_i && pix_sof_i) mode_q <= mode_i;
      s1_vld <= pix_valid_i;
      s1_sof <= pix_valid_i && pix_sof_i;
      s1_sol <= pix_valid_i && pix_sol_i;
      if (pix_valid_i) begin
        s1_data  <= pix_data_i;
        s1_bad   <= in_bad;
        s1_first <= in_first;
        s1_last  <= in_last;
        s1_mode  <= in_mode;
      end
      if (s1_vld) begin
        lft_data   <= s1_data;
        lft_bad    <= s1_bad;
        pix_data_o <= fix_data;
      end
      pix_valid_o <= s1_vld;
      pix_sof_o   <= s1_sof;
      pix_sol_o   <= s1_sol;
    end
  end
endmodule

// File: rtl/dpc_pixel_fix_chk.sv
module dpc_pixel_fix_chk #(
  parameter int PIX_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             pix_valid_i,
  input logic             pix_sof_i,
  input logic             pix_sol_i,
  input logic [PIX_W-1:0] pix_data_i,
  input logic             pix_valid_o,
  input logic             pix_sof_o,
  input logic             pix_sol_o,
  input logic [PIX_W-1:0] pix_data_o,
  input logic [1:0]       in_cls,
  input logic             in_first,
  input logic             in_mode
);
  logic [1:0] age_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  AST_FIXED_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q >= 2'd2) |-> (pix_valid_o == $past(pix_valid_i, 2))); // R1

  AST_SOF_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q >= 2'd2) |-> (pix_sof_o == $past(pix_valid_i && pix_sof_i, 2))); // R1

  AST_SOL_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q >= 2'd2) |-> (pix_sol_o == $past(pix_valid_i && pix_sol_i, 2))); // R1

  AST_GOOD_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q >= 2'd2 && $past(pix_valid_i && in_cls == 2'b00, 2))
      |-> (pix_data_o == $past(pix_data_i, 2))); // R2

  AST_COPY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q >= 2'd2 && $past(pix_valid_i && in_cls != 2'b00 && !in_first && !in_mode, 2))
      |-> (pix_data_o == $past(pix_data_o))); // R5
endmodule

bind dpc_pixel_fix dpc_pixel_fix_chk #(
  .PIX_W(PIX_W)
) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .pix_valid_i(pix_valid_i),
  .pix_sof_i  (pix_sof_i),
  .pix_sol_i  (pix_sol_i),
  .pix_data_i (pix_data_i),
  .pix_valid_o(pix_valid_o),
  .pix_sof_o  (pix_sof_o),
  .pix_sol_o  (pix_sol_o),
  .pix_data_o (pix_data_o),
  .in_cls     (in_cls),
  .in_first   (in_first),
  .in_mode    (in_mode)
);

// File: tb/test_dpc_pixel_fix.sv
module test_dpc_pixel_fix;
  localparam int CLK_PERIOD = 10;
  localparam int PW = 8;
  localparam int W  = 6;
  localparam int H  = 3;
  localparam int AW = $clog2(W*H);

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          mode_i = 1'b0;
  logic          map_we_i = 1'b0;
  logic [AW-1:0] map_waddr_i = '0;
  logic [1:0]    map_cls_i = '0;
  logic          pix_valid_i = 1'b0;
  logic          pix_sof_i = 1'b0;
  logic          pix_sol_i = 1'b0;
  logic [PW-1:0] pix_data_i = '0;
  logic          pix_valid_o, pix_sof_o, pix_sol_o;
  logic [PW-1:0] pix_data_o;

  dpc_pixel_fix #(.PIX_W(PW), .LINE_PIX(W), .FRAME_LINES(H)) i_dpc_pixel_fix (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode_i),
    .map_we_i(map_we_i), .map_waddr_i(map_waddr_i), .map_cls_i(map_cls_i),
    .pix_valid_i(pix_valid_i), .pix_sof_i(pix_sof_i), .pix_sol_i(pix_sol_i),
    .pix_data_i(pix_data_i),
    .pix_valid_o(pix_valid_o), .pix_sof_o(pix_sof_o), .pix_sol_o(pix_sol_o),
    .pix_data_o(pix_data_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int n_chk = 0;
  int n_err = 0;
  int img [H][W];
  int mp  [H][W];
  int prev_exp = 0;
  int exp_data [256];
  bit exp_sof [256];
  bit exp_sol [256];
  int exp_wr = 0;
  int exp_rd = 0;
  bit mon_en = 1'b0;
  string cur_tag = "R1";

  task automatic check(input string tag, input int act, input int expv);
    n_chk++;
    if (act != expv) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic finish_up();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog actual=running expected=done");
    finish_up();
  end

  // output monitor against the expected queue
  always @(negedge clk_i) begin
    if (mon_en && pix_valid_o) begin
      if (exp_rd >= exp_wr) begin
        check({cur_tag, " extra output"}, 1, 0);
      end else begin
        check({cur_tag, " data"}, int'(pix_data_o), exp_data[exp_rd]);
        check({cur_tag, " sof R1"}, int'(pix_sof_o), int'(exp_sof[exp_rd]));
        check({cur_tag, " sol R1"}, int'(pix_sol_o), int'(exp_sol[exp_rd]));
        exp_rd++;
      end
    end
  end

  task automatic write_map(input int r, input int c, input int cls);
    @(negedge clk_i);
    map_we_i    = 1'b1;
    map_waddr_i = AW'(r*W + c);
    map_cls_i   = 2'(cls);
    @(negedge clk_i);
    map_we_i = 1'b0;
    mp[r][c] = cls;
  endtask

  task automatic clear_map();
    for (int r = 0; r < H; r++)
      for (int c = 0; c < W; c++)
        if (mp[r][c] != 0) write_map(r, c, 0);
  endtask

  task automatic fill_img(input int seed);
    for (int r = 0; r < H; r++)
      for (int c = 0; c < W; c++)
        img[r][c] = (r*37 + c*53 + seed*29 + 7) % 256;
  endtask

  // reference model written from the requirements
  task automatic expect_frame(input int md);
    for (int r = 0; r < H; r++) begin
      for (int c = 0; c < W; c++) begin
        int v, lv, rv;
        bit lb, rb;
        v = img[r][c];
        if (mp[r][c] != 0) begin
          if (md == 0) begin
            v = (c == 0 && mp[r][1] == 0) ? img[r][1] : prev_exp;
          end else begin
            lv = (c == 0)   ? img[r][1]   : img[r][c-1];
            lb = (c == 0)   ? (mp[r][1] != 0) : (mp[r][c-1] != 0);
            rv = (c == W-1) ? img[r][c-1] : img[r][c+1];
            rb = (c == W-1) ? (mp[r][c-1] != 0) : (mp[r][c+1] != 0);
            if (!lb && !rb) v = (lv + rv + 1) / 2;
            else if (!lb)   v = lv;
            else if (!rb)   v = rv;
            else            v = prev_exp;
          end
        end
        prev_exp = v;
        exp_data[exp_wr] = v;
        exp_sof[exp_wr]  = (r == 0 && c == 0);
        exp_sol[exp_wr]  = (c == 0);
        exp_wr++;
      end
    end
  endtask

  task automatic send_frame(input int md, input bit flip_mid);
    expect_frame(md);
    for (int r = 0; r < H; r++) begin
      for (int c = 0; c < W; c++) begin
        @(negedge clk_i);
        if (r == 0 && c == 0) mode_i = md[0];
        if (flip_mid && r == 1 && c == 0) mode_i = ~md[0];
        pix_valid_i = 1'b1;
        pix_sof_i   = (r == 0 && c == 0);
        pix_sol_i   = (c == 0);
        pix_data_i  = PW'(img[r][c]);
      end
      @(negedge clk_i);
      pix_valid_i = 1'b0;
      pix_sof_i   = 1'b0;
      pix_sol_i   = 1'b0;
    end
    repeat (4) @(negedge clk_i);
    check({cur_tag, " R4 count"}, exp_rd, exp_wr);
  endtask

  task automatic t_reset();
    cur_tag = "R11";
    repeat (3) @(negedge clk_i);
    check("R11 valid after reset", int'(pix_valid_o), 0);
    check("R11 sof after reset", int'(pix_sof_o), 0);
    check("R11 sol after reset", int'(pix_sol_o), 0);
  endtask

  task automatic t_latency();
    cur_tag = "R1";
    @(negedge clk_i);
    pix_valid_i = 1'b1; pix_sof_i = 1'b1; pix_sol_i = 1'b1; pix_data_i = 8'd77;
    @(negedge clk_i);
    pix_valid_i = 1'b0; pix_sof_i = 1'b0; pix_sol_i = 1'b0; pix_data_i = 8'd0;
    check("R1 not yet valid after 1 clock", int'(pix_valid_o), 0);
    @(negedge clk_i);
    check("R1 valid after 2 clocks", int'(pix_valid_o), 1);
    check("R1 sof after 2 clocks", int'(pix_sof_o), 1);
    check("R1 sol after 2 clocks", int'(pix_sol_o), 1);
    check("R1 R2 data after 2 clocks", int'(pix_data_o), 77);
    @(negedge clk_i);
    check("R1 single beat", int'(pix_valid_o), 0);
    prev_exp = 77;
  endtask

  task automatic t_fresh_map();
    cur_tag = "R11 R2";
    fill_img(1);
    send_frame(1, 1'b0);
  endtask

  task automatic place_defects();
    write_map(0, 0, 1);
    write_map(0, 3, 2);
    write_map(0, 4, 3);
    write_map(1, 2, 3);
    write_map(1, 5, 1);
    write_map(2, 0, 3);
    write_map(2, 1, 1);
  endtask

  task automatic t_copy();
    cur_tag = "R3 R5 R6";
    place_defects();
    fill_img(2);
    send_frame(0, 1'b0);
  endtask

  task automatic t_avg();
    cur_tag = "R7 R8 R9 R4";
    fill_img(3);
    send_frame(1, 1'b0);
    fill_img(4);
    send_frame(1, 1'b0);
  endtask

  task automatic t_round();
    cur_tag = "R7 round";
    fill_img(5);
    img[1][1] = 255; img[1][3] = 254;
    send_frame(1, 1'b0);
    img[1][1] = 10; img[1][3] = 13;
    send_frame(1, 1'b0);
  endtask

  task automatic t_mode_latch();
    cur_tag = "R10";
    fill_img(6);
    send_frame(0, 1'b1);
    fill_img(7);
    send_frame(1, 1'b1);
  endtask

  task automatic t_rewrite();
    cur_tag = "R3 R2 rewrite";
    clear_map();
    write_map(1, 3, 2);
    fill_img(8);
    send_frame(1, 1'b0);
  endtask

  initial begin
    for (int r = 0; r < H; r++)
      for (int c = 0; c < W; c++)
        mp[r][c] = 0;
    rst_ni = 1'b0;
    repeat (4) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_latency();
    mon_en = 1'b1;
    t_fresh_map();
    t_copy();
    t_avg();
    t_round();
    t_mode_latch();
    t_rewrite();
    finish_up();
  end
endmodule